// File: doc/BRIEF.md
# Masked Find-First Mask Generator

This unit turns a 64-bit source mask into a mask derived from its lowest set bit, taking part only where a predicate allows. A 2-bit opcode picks the result:
- everything below the first set bit,
- everything up to and including it,
- only that bit itself.

The search for the first set bit looks only at predicate-enabled positions. A source bit that is set at a disabled position is skipped as if it were clear.

Destination positions whose predicate bit is clear are not written. They carry the caller's previous destination value, supplied on `in_old`. A select input replaces the predicate with all ones, so that the unmasked form needs no separate mask operand.

A request is taken with a valid/ready handshake, and the result appears registered one cycle later. The output holds while the consumer stalls.

Top module: `ffmask_unit`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Opcode 2'b00 (before-first) writes 1 to every active position below the lowest active set source bit, and 0 at that bit and above. Bit 0 is the least significant bit and the search runs upward from it. Example: source 0x94 gives 0x03.
- R3: In before-first mode, when no active source bit is set, every active position is written 1.
- R4: Opcode 2'b01 (including-first) gives the before-first result with the first active set bit also written 1. Example: source 0x94 gives 0x07.
- R5: Opcode 2'b10 (only-first) writes 1 only at the first active set bit and 0 at every other active position. It writes all zeros when no active source bit is set.
- R6: A source bit whose predicate bit is 0 does not count as the first set bit.
- R7: Each output position whose effective predicate bit is 0 equals the matching bit of in_old.
- R8: When in_pred_all is 1, in_pred is ignored and every position is active.
- R9: Opcode 2'b11 writes no position, so out_mask equals in_old.
- R10: A request is accepted on a clock edge where in_valid and in_ready are both 1, and its result shows on out_mask with out_valid 1 after that edge. in_ready is 1 exactly when out_valid is 0 or out_ready is 1. While out_valid is 1 and out_ready is 0, out_mask and out_valid hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 2 | 00 before-first, 01 including-first, 10 only-first, 11 no write |
| in_pred_all | input | 1 | Treat every position as active |
| in_src | input | 64 | Source mask |
| in_pred | input | 64 | Predicate mask, 1 = active |
| in_old | input | 64 | Previous destination value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | 64 | Result mask |

## Verification
Only one register holds state: the output stage. A wrong value there shows at the ports in the cycle right after the accepting edge, as a bit flipped in the active or passed-through field. A handshake fault shows up within a single stall cycle, as a dropped, duplicated or changed result. The checks compare every bit against values worked out from the predicate and the opcode. They include sources whose first set bit sits at a disabled position, and the extreme case of bit 63.

// File: rtl/ffmask_unit.sv
module ffmask_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic         in_pred_all,
  input  logic [W-1:0] in_src,
  input  logic [W-1:0] in_pred,
  input  logic [W-1:0] in_old,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_mask
);
  localparam logic [1:0] OP_BEFORE = 2'd0;
  localparam logic [1:0] OP_INCL   = 2'd1;
  localparam logic [1:0] OP_ONLY   = 2'd2;

  logic [W-1:0] pred, act, first, below, gen, wen, res;

  assign pred  = in_pred_all ? {W{1'b1}} : in_pred;
  assign act   = in_src & pred;
  assign first = act & (~act + W'(1));
  assign below = first - W'(1);

  always_comb begin
    case (in_op)
      OP_BEFORE: gen = below;
      OP_INCL:   gen = below | first;
      OP_ONLY:   gen = first;
      default:   gen = '0;
    endcase
  end

  assign wen      = (in_op == 2'd3) ? '0 : pred;
  assign res      = (gen & wen) | (in_old & ~wen);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_mask  <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

module ffmask_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   in_op,
  input logic         in_pred_all,
  input logic [W-1:0] in_src,
  input logic [W-1:0] in_pred,
  input logic [W-1:0] in_old,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_mask
);
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mask)); // R10
  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !out_valid); // R10
  AST_KEEP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=>
      ((out_mask ^ $past(in_old)) & ($past(in_pred_all) ? {W{1'b0}} : ~$past(in_pred))) == '0); // R7
  AST_ONLY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 2'd2 |=>
      $onehot0(out_mask & ($past(in_pred_all) ? {W{1'b1}} : $past(in_pred)))); // R5
  AST_NOWRITE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 2'd3 |=> out_mask == $past(in_old)); // R9
endmodule

bind ffmask_unit ffmask_unit_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_pred_all(in_pred_all), .in_src(in_src), .in_pred(in_pred),
  .in_old(in_old), .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask)
);

// File: tb/ffmask_unit_test.sv
module ffmask_unit_test;
  typedef struct packed {
    logic [63:0] src;
    logic [63:0] pred;
    logic [63:0] old;
    logic [1:0]  op;
    logic        pall;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TAB [NV] = '{
    '{64'h94, 64'h0, 64'h0, 2'd0, 1'b1, 64'h3, 8'd2},                                      // R2
    '{64'h94, 64'h0, 64'h0, 2'd1, 1'b1, 64'h7, 8'd4},                                      // R4
    '{64'h94, 64'h0, 64'h0, 2'd2, 1'b1, 64'h4, 8'd5},                                      // R5
    '{64'h95, 64'h0, 64'h0, 2'd0, 1'b1, 64'h0, 8'd2},                                      // R2
    '{64'h0, 64'h0, 64'h0, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3},                     // R3
    '{64'h0, 64'h0, 64'hFF, 2'd2, 1'b1, 64'h0, 8'd5},                                      // R5
    '{64'h94, 64'hFFFF_FFFF_FFFF_FFF0, 64'hA, 2'd1, 1'b0, 64'h1A, 8'd6},                   // R6
    '{64'h94, 64'hC3, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FF7F, 8'd7}, // R7
    '{64'h0, 64'h0, 64'h5555, 2'd0, 1'b0, 64'h5555, 8'd7},                                 // R7
    '{64'h94, 64'h0, 64'h1234, 2'd3, 1'b1, 64'h1234, 8'd9},                                // R9
    '{64'h8000_0000_0000_0000, 64'h0, 64'h0, 2'd0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 8'd2},  // R2
    '{64'h8000_0000_0000_0000, 64'h0, 64'h0, 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 8'd4},  // R4
    '{64'h8000_0000_0000_0000, 64'h0, 64'h0, 2'd2, 1'b1, 64'h8000_0000_0000_0000, 8'd5},  // R5
    '{64'h94, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b1, 64'h4, 8'd8}                     // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = 2'd0;
  logic in_pred_all = 1'b0;
  logic [63:0] in_src = '0, in_pred = '0, in_old = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [63:0] out_mask;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ffmask_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_pred_all(in_pred_all), .in_src(in_src), .in_pred(in_pred),
    .in_old(in_old), .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] s, input logic [63:0] p, input logic [63:0] o,
                       input logic [1:0] op, input logic pa);
    in_src = s; in_pred = p; in_old = o; in_op = op; in_pred_all = pa; in_valid = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TAB[i].src, TAB[i].pred, TAB[i].old, TAB[i].op, TAB[i].pall);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vec%0d valid", TAB[i].req, i), 64'(out_valid), 64'd1);
      check($sformatf("R%0d vec%0d mask", TAB[i].req, i), out_mask, TAB[i].exp);
    end

    @(negedge clk);
    check("R10 drained", 64'(out_valid), 64'd0);

    // R10 stall: result A held, B blocked until out_ready returns
    out_ready = 1'b0;
    drive(64'h94, 64'h0, 64'h0, 2'd0, 1'b1);
    @(negedge clk);
    check("R10 A valid", 64'(out_valid), 64'd1);
    check("R10 ready low", 64'(in_ready), 64'd0);
    drive(64'h94, 64'h0, 64'h0, 2'd1, 1'b1);
    @(negedge clk);
    check("R10 A held", out_mask, 64'h3);
    check("R10 still valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    #1;
    check("R10 ready back", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 B taken", out_mask, 64'h7);
    @(negedge clk);
    check("R10 B drained", 64'(out_valid), 64'd0);

    // R6 first set bit at disabled position 2 is skipped in only-first mode
    drive(64'h94, 64'hFFFF_FFFF_FFFF_FFFB, 64'h0, 2'd2, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 skip disabled", out_mask, 64'h10);

    // R3 with predicate: active set bits absent, active positions all 1, rest old
    drive(64'h0F, 64'hF0, 64'h0, 2'd0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 masked none", out_mask, 64'hF0);

    // R1 reset again while a result is pending
    out_ready = 1'b0;
    drive(64'h1, 64'h0, 64'h0, 2'd0, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    check("R1 reset clears", 64'(out_valid), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule